// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an analog-to-digital converter begins each conversion sequence. Software starts the block with a one-cycle strobe that stands for a write to the sequence-start control register. Four static control bits choose the mode: external trigger enable, level-or-edge selection, trigger polarity and back-to-back scan. The converter answers every `seq_start_o` pulse with a `seq_done_i` pulse at the end of the sequence. The block reports whether a sequence is in progress and keeps a sticky flag for triggers that arrive too early.

With the external trigger off, the start strobe launches a sequence at once: one sequence, or an endless chain when scan is set. With the trigger on, the strobe only arms the block. In that case the synchronized trigger pin decides when sequences run. In edge mode each active edge starts one sequence, and an active edge that arrives during a sequence is recorded as an overrun. In level mode sequences follow each other for as long as the pin holds its active level, and a glitch inside a sequence is not an error.

Top module: `adc_trig_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy_o`, `overrun_o` and `seq_start_o` are 0. Reset also leaves the block unarmed, so trigger pin activity before the first start strobe starts nothing.
- R2: With `trig_en_i`=0 and `scan_i`=0, a start strobe in cycle c gives one `seq_start_o` pulse in cycle c+1. `busy_o` stays 1 from cycle c+1 until the cycle after the one in which `seq_done_i` is sampled, and then returns to 0. The trigger pin is ignored.
- R3: With `trig_en_i`=0 and `scan_i`=1, every sampled `seq_done_i` is followed in the next cycle by a new `seq_start_o` pulse, with `busy_o` held at 1. The trigger pin is ignored.
- R4: With `trig_en_i`=1, a start strobe starts no sequence: `seq_start_o` and `busy_o` stay 0 in the next cycle.
- R5: In edge mode (`trig_level_i`=0), an armed block starts one sequence per active edge. The active edge is falling for `trig_pol_i`=0 and rising for `trig_pol_i`=1. A pin change between edges k-1 and k gives `seq_start_o` in cycle k+2, after two synchronizer stages and one edge-detect stage. The opposite edge starts nothing.
- R6: In level mode (`trig_level_i`=1), an armed block starts a sequence when the pin is at its active level (low for polarity 0, high for polarity 1). If the pin is still at that level when `seq_done_i` is sampled, the next sequence starts in the following cycle.
- R7: In level mode, a sequence that completes while the pin is at its inactive level ends with `busy_o`=0, and the block stays armed until the level becomes active again.
- R8: In edge mode, an active edge seen while `busy_o`=1 sets `overrun_o` in the next cycle. The flag stays set and the edge starts no extra sequence.
- R9: In level mode, `overrun_o` is never set, including when the pin leaves and regains its active level during a sequence.
- R10: `overrun_o` is cleared in the cycle after `ovr_clr_i` or a start strobe. A start strobe clears it even if an overrun edge arrives in the same cycle.
- R11: `scan_i` has no effect while `trig_en_i`=1. In edge mode the block returns to armed after each sequence.
- R12: A start strobe during a sequence aborts it and selects the mode again from the current control bits. With the trigger off, a new `seq_start_o` follows in the next cycle. With the trigger on, `busy_o` drops in the next cycle and the block waits armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously |
| trig_en_i | input | 1 | 1 = sequences paced by the external trigger pin |
| trig_level_i | input | 1 | 1 = level-sensitive trigger, 0 = edge-sensitive |
| trig_pol_i | input | 1 | 0 = low level / falling edge active, 1 = high level / rising edge active |
| scan_i | input | 1 | 1 = back-to-back sequences when the trigger is off |
| start_wr_i | input | 1 | One-cycle strobe: write to the sequence-start register |
| ovr_clr_i | input | 1 | One-cycle strobe clearing the overrun flag |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| seq_done_i | input | 1 | One-cycle pulse from the converter at the end of a sequence |
| seq_start_o | output | 1 | One-cycle pulse launching a conversion sequence |
| busy_o | output | 1 | A sequence is in progress |
| overrun_o | output | 1 | Sticky edge-mode trigger overrun flag |

## Verification
The assertions assume that the control bits do not change in the same cycle as a start strobe or a sampled done pulse. They also assume that `seq_done_i` arrives only after at least one cycle of `busy_o`, as it would from a real converter. The bench keeps to this by changing mode bits only while the block is idle or armed. Its converter model is a down-counter that loads on `seq_start_o` and pulses done a fixed six cycles later. Trigger pin changes are placed at cycles computed from the synchronizer depth. Pin glitches are driven during the counted sequence window, so overrun and level-restart decisions fall on known cycles.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  // Sequencer control state
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  // Minimum depth for metastability protection on the trigger pin
  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/trig_sync.sv
// Pin synchronizer with a history flop for edge detection
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q[g] <= 1'b0;
        end else if (g == 0) begin
          chain_q[g] <= pin_i;
        end else begin
          chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b0;
    end else begin
      hist_q <= chain_q[LAST];
    end
  end

  assign lvl_o  = chain_q[LAST];
  assign rise_o = chain_q[LAST] & ~hist_q;
  assign fall_o = ~chain_q[LAST] & hist_q;

endmodule

// File: rtl/trig_qual.sv
// Polarity and mode qualification of the synchronized trigger
module trig_qual (
  input  logic lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic pol_i,
  input  logic level_mode_i,
  output logic hit_o,
  output logic act_edge_o
);
  logic act_lvl;

  always_comb begin
    act_lvl    = pol_i ? lvl_i : ~lvl_i;
    act_edge_o = pol_i ? rise_i : fall_i;
    hit_o      = level_mode_i ? act_lvl : act_edge_o;
  end

endmodule

// File: rtl/seq_ctrl.sv
// Sequence state machine and overrun flag
module seq_ctrl
  import adc_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_en_i,
  input  logic trig_level_i,
  input  logic scan_i,
  input  logic start_wr_i,
  input  logic ovr_clr_i,
  input  logic seq_done_i,
  input  logic hit_i,
  input  logic act_edge_i,
  output logic seq_start_o,
  output logic busy_o,
  output logic overrun_o
);
  seq_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       ovr_q, ovr_d, ovr_en;
  logic       ovr_set;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    if (start_wr_i) begin
      if (trig_en_i) begin
        state_d = ST_ARMED;
      end else begin
        state_d = ST_RUN;
        start_d = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_ARMED: begin
          if (trig_en_i && hit_i) begin
            state_d = ST_RUN;
            start_d = 1'b1;
          end
        end
        ST_RUN: begin
          if (seq_done_i) begin
            if (trig_en_i) begin
              if (trig_level_i && hit_i) begin
                start_d = 1'b1;
              end else begin
                state_d = ST_ARMED;
              end
            end else if (scan_i) begin
              start_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Overrun flag: start strobe wins, then a new overrun, then the clear strobe
  always_comb begin
    ovr_set = (state_q == ST_RUN) && trig_en_i && !trig_level_i && act_edge_i;
    ovr_en  = start_wr_i | ovr_set | ovr_clr_i;
    if (start_wr_i) begin
      ovr_d = 1'b0;
    end else if (ovr_set) begin
      ovr_d = 1'b1;
    end else begin
      ovr_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
    end else if (ovr_en) begin
      ovr_q <= ovr_d;
    end
  end

  assign seq_start_o = start_q;
  assign busy_o      = (state_q == ST_RUN);
  assign overrun_o   = ovr_q;

endmodule

// File: rtl/adc_trig_seq.sv
// Conversion trigger sequencer top
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_en_i,
  input  logic trig_level_i,
  input  logic trig_pol_i,
  input  logic scan_i,
  input  logic start_wr_i,
  input  logic ovr_clr_i,
  input  logic trig_pin_i,
  input  logic seq_done_i,
  output logic seq_start_o,
  output logic busy_o,
  output logic overrun_o
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic pin_lvl, pin_rise, pin_fall;
  logic hit, act_edge;

  trig_sync #(.STAGES(STAGES_USED)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (trig_pin_i),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  trig_qual i_qual (
    .lvl_i        (pin_lvl),
    .rise_i       (pin_rise),
    .fall_i       (pin_fall),
    .pol_i        (trig_pol_i),
    .level_mode_i (trig_level_i),
    .hit_o        (hit),
    .act_edge_o   (act_edge)
  );

  seq_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_en_i    (trig_en_i),
    .trig_level_i (trig_level_i),
    .scan_i       (scan_i),
    .start_wr_i   (start_wr_i),
    .ovr_clr_i    (ovr_clr_i),
    .seq_done_i   (seq_done_i),
    .hit_i        (hit),
    .act_edge_i   (act_edge),
    .seq_start_o  (seq_start_o),
    .busy_o       (busy_o),
    .overrun_o    (overrun_o)
  );

endmodule

// File: rtl/adc_trig_seq_chk.sv
// Property checker bound to the sequencer top
module adc_trig_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_en_i,
  input logic trig_level_i,
  input logic scan_i,
  input logic start_wr_i,
  input logic seq_done_i,
  input logic seq_start_o,
  input logic busy_o,
  input logic overrun_o
);

  AST_START_WHEN_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i && !trig_en_i |=> seq_start_o && busy_o); // R2

  AST_SINGLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && seq_done_i && !trig_en_i && !scan_i && !start_wr_i |=> !busy_o && !seq_start_o); // R2

  AST_SCAN_CHAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && seq_done_i && !trig_en_i && scan_i && !start_wr_i |=> seq_start_o && busy_o); // R3

  AST_ARM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i && trig_en_i |=> !seq_start_o && !busy_o); // R4

  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> seq_start_o); // R12

  AST_START_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |-> busy_o); // R12

  AST_OVR_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(busy_o && trig_en_i && !trig_level_i)); // R8

  AST_OVR_NOT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(!trig_level_i)); // R9

  AST_OVR_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |=> !overrun_o); // R10

endmodule

bind adc_trig_seq adc_trig_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_en_i    (trig_en_i),
  .trig_level_i (trig_level_i),
  .scan_i       (scan_i),
  .start_wr_i   (start_wr_i),
  .seq_done_i   (seq_done_i),
  .seq_start_o  (seq_start_o),
  .busy_o       (busy_o),
  .overrun_o    (overrun_o)
);

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  localparam int CONV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_en = 1'b0, trig_level = 1'b0, trig_pol = 1'b0, scan = 1'b0;
  logic start_wr = 1'b0, ovr_clr = 1'b0, pin = 1'b1;
  logic seq_done, seq_start, busy, overrun;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cnt = 0;
  string cur_req = "R1";
  int    exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter stand-in: done CONV cycles after the start pulse is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (seq_start) cnt <= CONV;
    else if (cnt > 0) cnt <= cnt - 1;
  end
  assign seq_done = (cnt == 1);

  adc_trig_seq i_adc_trig_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .trig_en_i    (trig_en),
    .trig_level_i (trig_level),
    .trig_pol_i   (trig_pol),
    .scan_i       (scan),
    .start_wr_i   (start_wr),
    .ovr_clr_i    (ovr_clr),
    .trig_pin_i   (pin),
    .seq_done_i   (seq_done),
    .seq_start_o  (seq_start),
    .busy_o       (busy),
    .overrun_o    (overrun)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: cycle %0d actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic expect_start(input int c, input string req);
    exp_q.push_back(c);
    req_q.push_back(req);
  endtask

  // Monitor: pop expected start cycles as pulses appear
  always @(negedge clk) begin
    if (rst_n && seq_start) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s: start pulse at cycle %0d actual 1 expected 0", cur_req, cyc);
      end else begin
        chk(req_q.pop_front(), cyc, exp_q.pop_front());
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive_at(input int n);
    while (cyc < n) step();
  endtask

  task automatic at_neg(input int n);
    forever begin
      @(negedge clk);
      if (cyc >= n) break;
    end
  endtask

  task automatic pulse_start();
    start_wr = 1'b1;
    step();
    start_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c, d, f, g, h, k, m, n;
    repeat (3) @(posedge clk);
    // R1: reset values
    chk("R1", busy, 0);
    chk("R1", overrun, 0);
    #2 rst_n = 1'b1;
    at_neg(cyc);
    chk("R1", busy, 0);
    chk("R1", overrun, 0);
    chk("R1", seq_start, 0);
    // R1: not armed after reset, pin edges start nothing
    trig_en = 1'b1;
    step();
    for (int i = 0; i < 8; i++) begin pin = ~pin; step(); step(); end
    at_neg(cyc + 4);
    chk("R1", busy, 0);

    // R2: single sequence, pin ignored
    cur_req = "R2";
    trig_en = 1'b0; scan = 1'b0;
    step();
    c = cyc;
    expect_start(c + 1, "R2");
    pulse_start();
    at_neg(c + 1);
    chk("R2", busy, 1);
    for (int i = 0; i < 4; i++) begin step(); pin = ~pin; end
    at_neg(c + 7);
    chk("R2", busy, 1);
    at_neg(c + 8);
    chk("R2", busy, 0);
    drive_at(c + 20);

    // R3: scan chains sequences, pin ignored
    cur_req = "R3";
    scan = 1'b1;
    c = cyc;
    expect_start(c + 1, "R3");
    expect_start(c + 8, "R3");
    expect_start(c + 15, "R3");
    pulse_start();
    for (int i = 0; i < 10; i++) begin pin = ~pin; step(); end
    at_neg(c + 14);
    chk("R3", busy, 1);
    drive_at(c + 16);
    scan = 1'b0;
    at_neg(c + 21);
    chk("R3", busy, 1);
    at_neg(c + 22);
    chk("R3", busy, 0);
    drive_at(c + 26);

    // R12: abort and restart with the trigger off
    cur_req = "R12";
    c = cyc;
    expect_start(c + 1, "R12");
    pulse_start();
    drive_at(c + 3);
    expect_start(c + 4, "R12");
    pulse_start();
    at_neg(c + 10);
    chk("R12", busy, 1);
    at_neg(c + 11);
    chk("R12", busy, 0);

    // R4, R5, R11: edge mode, falling edges, scan set but ignored
    cur_req = "R4";
    step();
    trig_en = 1'b1; trig_level = 1'b0; trig_pol = 1'b0; scan = 1'b1; pin = 1'b1;
    repeat (4) step();
    c = cyc;
    pulse_start();
    at_neg(c + 2);
    chk("R4", busy, 0);
    drive_at(c + 5);
    cur_req = "R5";
    d = cyc;
    pin = 1'b0;
    expect_start(d + 3, "R5");
    at_neg(d + 10);
    chk("R11", busy, 0);
    drive_at(d + 12);
    pin = 1'b1;
    drive_at(d + 16);
    f = cyc;
    pin = 1'b0;
    expect_start(f + 3, "R5");
    // R8: extra falling edge mid-sequence
    cur_req = "R8";
    drive_at(f + 4); pin = 1'b1;
    drive_at(f + 5); pin = 1'b0;
    at_neg(f + 6);
    chk("R8", overrun, 0);
    at_neg(f + 9);
    chk("R8", overrun, 1);
    at_neg(f + 20);
    chk("R8", overrun, 1);
    chk("R11", busy, 0);
    // R10: clear strobe
    step();
    g = cyc;
    ovr_clr = 1'b1;
    step();
    ovr_clr = 1'b0;
    at_neg(g + 1);
    chk("R10", overrun, 0);

    // R5 rising edges; R8 again; R10/R12 via start write during a sequence
    cur_req = "R5";
    step();
    trig_pol = 1'b1;
    step(); step();
    h = cyc;
    pin = 1'b1;
    expect_start(h + 3, "R5");
    drive_at(h + 4); pin = 1'b0;
    drive_at(h + 5); pin = 1'b1;
    at_neg(h + 8);
    chk("R8", overrun, 1);
    drive_at(h + 9);
    pulse_start();
    at_neg(h + 10);
    chk("R12", busy, 0);
    chk("R10", overrun, 0);
    drive_at(h + 16);

    // R6, R7, R9: level mode, high active
    cur_req = "R6";
    pin = 1'b0;
    repeat (4) step();
    trig_level = 1'b1;
    step(); step();
    k = cyc;
    pin = 1'b1;
    expect_start(k + 3, "R6");
    expect_start(k + 10, "R6");
    drive_at(k + 5); pin = 1'b0;
    drive_at(k + 6); pin = 1'b1;
    drive_at(k + 12); pin = 1'b0;
    at_neg(k + 17);
    chk("R7", busy, 0);
    chk("R9", overrun, 0);
    cur_req = "R7";
    drive_at(k + 20);
    m = cyc;
    pin = 1'b1;
    expect_start(m + 3, "R7");
    drive_at(m + 4); pin = 1'b0;
    at_neg(m + 11);
    chk("R7", busy, 0);

    // R6: low-active level, pin already low
    cur_req = "R6";
    step();
    n = cyc;
    trig_pol = 1'b0;
    expect_start(n + 1, "R6");
    drive_at(n + 2); pin = 1'b1;
    at_neg(n + 8);
    chk("R6", busy, 0);
    chk("R9", overrun, 0);
    repeat (6) step();
    chk("R6", exp_q.size(), 0);
    finish_run();
  end

endmodule